// File: doc/BRIEF.md
# Fractional Output Divider with Triangle Spread

This block divides a fast oscillator clock by a programmable ratio with a 12-bit integer part and a 24-bit fractional part. It emits a one-cycle enable pulse, `div_pulse_o`, at the end of every output period. The fraction is applied through a first-order accumulator. In each output period the fraction is added to a 24-bit accumulator. A period whose addition overflows lasts one cycle longer than the integer value. Over time the average period therefore equals integer + fraction / 2^24.

Three modes change the basic divide. A bypass mode makes every input cycle a period, so the block divides by one. An integer-only mode switches the accumulator off, so every period equals the integer value exactly. A spread mode adds a signed triangle offset to the fraction. The offset moves by a programmable increment once every K output periods and turns round at plus or minus a programmable amplitude.

A shared sync input restarts the counter and clears all fractional and spread state, so that every divider fed by the same pulse restarts on the same cycle. The divider reads its configuration only at a period boundary. The period in progress is never changed by a configuration write.

Top module: `frac_out_div`

## Requirements
- R1: Outside bypass, the number of input cycles from one output pulse to the next is the effective integer N or N+1. It is never anything else.
- R2: At each boundary the effective fraction is added to a 24-bit accumulator, which starts at zero. A carry out of bit 23 makes the next period N+1. Otherwise the next period is N.
- R3: When integer-only is set at a boundary, the next period is exactly N and the accumulator is cleared to zero.
- R4: When bypass is set at a boundary, the next output pulse follows on the very next cycle, so the pulse stays high on every cycle while bypass holds.
- R5: An integer field of 0 or 1 is treated as N = 2 outside bypass. Values from 2 to 4095 are used as given.
- R6: In the cycle after sync is sampled high, the pulse is low. In the cycle after that, the pulse is high. The accumulator, the offset, the spread direction and the period tick count are all cleared, so dividers sharing the sync restart together.
- R7: While reset is low the pulse is low. The first pulse appears one cycle after reset is released, and it starts from the same cleared state as after sync.
- R8: Configuration inputs are sampled only at a boundary. A change in mid-period leaves the length of the current period unchanged and applies from the next boundary on.
- R9: With spread enabled, the offset moves once every K boundaries, where K is the rate field and 0 counts as 1. Each move adds the increment while the direction is up and subtracts it while the direction is down. A move that would reach +amplitude sets the offset to +amplitude and turns the direction down. A move that would reach -amplitude sets it to -amplitude and turns the direction up. The direction starts up.
- R10: The effective fraction is the fraction field plus the offset, clamped to the range 0 to 2^24-1. It is used before the offset moves at that boundary. With spread disabled at a boundary, the offset and the tick count are cleared and the direction returns to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_i | input | 1 | Alignment pulse shared by all dividers |
| cfg_int_i | input | 12 | Integer part of the divide ratio |
| cfg_frac_i | input | 24 | Fractional part of the divide ratio, in units of 2^-24 |
| cfg_bypass_i | input | 1 | Divide by one |
| cfg_int_only_i | input | 1 | Ignore the fraction and the spread; integer divide only |
| cfg_ss_en_i | input | 1 | Enable the triangle spread offset |
| cfg_ss_inc_i | input | 24 | Offset change per spread step |
| cfg_ss_amp_i | input | 24 | Offset limit; turning points at plus and minus this value |
| cfg_ss_rate_i | input | 16 | Output periods per spread step (0 treated as 1) |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each output period |

## Verification
On every cycle the assertions check four things. A boundary loads a period of N or N+1. Integer-only mode loads exactly N and clears the accumulator. Bypass yields back-to-back pulses. Sync and disabled spread clear their state, and the offset holds still between spread steps.

Other behaviour can only be shown by the bench scenarios, which compare each measured pulse interval with a cycle-exact model. This covers the exact sequence of N and N+1 periods produced by the accumulator and the path of the triangle offset through its turning points. It also covers the clamping of the effective fraction, the treatment of small integer values, writes made in mid-period, and the start-up timing after reset and sync.

// File: rtl/fod_pkg.sv
// Shared types for the fractional output divider.
package fod_pkg;
    // Direction of the triangle spread offset.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tri_dir_e;
endpackage

// File: rtl/fod_tri_mod.sv
// Triangle spread generator.
// Keeps a signed offset that moves by inc_i once every rate_i boundaries
// (rate 0 acts as 1). It turns round at +/-amp_i, saturating there.
// Assumes step_i is one cycle wide at each output boundary and that clr_i
// (sync) takes priority over step_i.
module fod_tri_mod
    import fod_pkg::*;
#(
    parameter int FRAC_W = 24,
    parameter int RATE_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     step_i,
    input  logic                     en_i,
    input  logic [FRAC_W-1:0]        inc_i,
    input  logic [FRAC_W-1:0]        amp_i,
    input  logic [RATE_W-1:0]        rate_i,
    output logic signed [FRAC_W:0]   off_o
);
    localparam int OW = FRAC_W + 1;
    localparam int XW = FRAC_W + 2;

    logic signed [OW-1:0] off_q;
    tri_dir_e             dir_q;
    logic [RATE_W-1:0]    tick_q;

    logic signed [XW-1:0] off_x, inc_x, amp_x, namp_x, up_n, dn_n;
    logic                 last_tick;

    // Widen the operands and form both candidate offsets.
    always_comb begin
        off_x     = {off_q[OW-1], off_q};
        inc_x     = {2'b00, inc_i};
        amp_x     = {2'b00, amp_i};
        namp_x    = -amp_x;
        up_n      = off_x + inc_x;
        dn_n      = off_x - inc_x;
        last_tick = (rate_i == '0) || (tick_q >= rate_i - RATE_W'(1));
    end

    // Advance the tick count and move or turn the offset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            off_q  <= '0;
            dir_q  <= DIR_UP;
            tick_q <= '0;
        end else if (step_i) begin
            if (!en_i) begin
                off_q  <= '0;
                dir_q  <= DIR_UP;
                tick_q <= '0;
            end else if (last_tick) begin
                tick_q <= '0;
                if (dir_q == DIR_UP) begin
                    if (up_n >= amp_x) begin
                        off_q <= amp_x[OW-1:0];
                        dir_q <= DIR_DOWN;
                    end else begin
                        off_q <= up_n[OW-1:0];
                    end
                end else begin
                    if (dn_n <= namp_x) begin
                        off_q <= namp_x[OW-1:0];
                        dir_q <= DIR_UP;
                    end else begin
                        off_q <= dn_n[OW-1:0];
                    end
                end
            end else begin
                tick_q <= tick_q + RATE_W'(1);
            end
        end
    end

    assign off_o = off_q;

    // R10
    ss_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !en_i) |=> (off_q == '0 && tick_q == '0));

    // R9
    ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && en_i && !last_tick) |=> (off_q == $past(off_q)));
endmodule

// File: rtl/fod_frac_acc.sv
// Fractional accumulator and period-length selection.
// Forms the effective fraction (fraction plus spread offset, clamped) and
// adds it to a 24-bit accumulator at each boundary. It returns the next
// period length minus one: N-1 or N, or 0 in bypass.
// Assumes step_i marks a boundary and clr_i (sync) takes priority.
module fod_frac_acc #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    step_i,
    input  logic [INT_W-1:0]        int_i,
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic signed [FRAC_W:0]  off_i,
    input  logic                    int_only_i,
    input  logic                    bypass_i,
    output logic [INT_W-1:0]        len_m1_o
);
    localparam int XW = FRAC_W + 2;
    localparam logic signed [XW-1:0] MAX_X = {2'b00, {FRAC_W{1'b1}}};

    logic [FRAC_W-1:0]    acc_q;
    logic signed [XW-1:0] raw;
    logic [FRAC_W-1:0]    eff;
    logic [FRAC_W:0]      sum;
    logic [INT_W-1:0]     n_m1;

    // Clamp the modulated fraction and pick the next period length.
    always_comb begin
        raw = {2'b00, frac_i} + {off_i[FRAC_W], off_i};
        if (int_only_i)        eff = '0;
        else if (raw < 0)      eff = '0;
        else if (raw > MAX_X)  eff = '1;
        else                   eff = raw[FRAC_W-1:0];
        sum  = {1'b0, acc_q} + {1'b0, eff};
        n_m1 = (int_i < INT_W'(2)) ? INT_W'(1) : int_i - INT_W'(1);
        len_m1_o = bypass_i ? '0 : n_m1 + INT_W'(sum[FRAC_W]);
    end

    // Keep the fractional residue from one boundary to the next.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  acc_q <= '0;
        else if (step_i)      acc_q <= int_only_i ? '0 : sum[FRAC_W-1:0];
    end

    // R3
    intonly_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && int_only_i) |=> (acc_q == '0));
endmodule

// File: rtl/fod_period_cnt.sv
// Period down-counter.
// Counts the remaining cycles of the current output period and loads the
// next length at zero. It raises the registered output pulse in the cycle
// after each boundary. Sync forces the count to zero with the pulse low.
module fod_period_cnt #(
    parameter int INT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [INT_W-1:0] len_m1_i,
    output logic             bnd_o,
    output logic [INT_W-1:0] cnt_o,
    output logic             pulse_o
);
    logic [INT_W-1:0] cnt_q;
    logic             pulse_q;

    assign bnd_o   = (cnt_q == '0);
    assign cnt_o   = cnt_q;
    assign pulse_o = pulse_q;

    // Count down, reload at the boundary and flag the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_i) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q   <= len_m1_i;
            pulse_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q - INT_W'(1);
            pulse_q <= 1'b0;
        end
    end

    // R6
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (!pulse_q && cnt_q == '0));
endmodule

// File: rtl/frac_out_div.sv
// Fractional output divider top.
// Ties the period counter, the fractional accumulator and the triangle
// spread generator together. All configuration is taken at a boundary
// only. Sync clears every piece of state for multi-divider alignment.
module frac_out_div #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 24,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [INT_W-1:0]  cfg_int_i,
    input  logic [FRAC_W-1:0] cfg_frac_i,
    input  logic              cfg_bypass_i,
    input  logic              cfg_int_only_i,
    input  logic              cfg_ss_en_i,
    input  logic [FRAC_W-1:0] cfg_ss_inc_i,
    input  logic [FRAC_W-1:0] cfg_ss_amp_i,
    input  logic [RATE_W-1:0] cfg_ss_rate_i,
    output logic              div_pulse_o
);
    logic                   bnd, step;
    logic [INT_W-1:0]       cnt, len_m1;
    logic signed [FRAC_W:0] off;

    // A boundary that is not overridden by sync advances the state.
    assign step = bnd && !sync_i;

    fod_period_cnt #(.INT_W(INT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .len_m1_i(len_m1),
        .bnd_o(bnd), .cnt_o(cnt), .pulse_o(div_pulse_o)
    );

    fod_frac_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(sync_i), .step_i(step),
        .int_i(cfg_int_i), .frac_i(cfg_frac_i), .off_i(off),
        .int_only_i(cfg_int_only_i), .bypass_i(cfg_bypass_i),
        .len_m1_o(len_m1)
    );

    fod_tri_mod #(.FRAC_W(FRAC_W), .RATE_W(RATE_W)) u_tri (
        .clk(clk), .rst_n(rst_n), .clr_i(sync_i), .step_i(step),
        .en_i(cfg_ss_en_i), .inc_i(cfg_ss_inc_i), .amp_i(cfg_ss_amp_i),
        .rate_i(cfg_ss_rate_i), .off_o(off)
    );

    // R1
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cfg_bypass_i && cfg_int_i >= INT_W'(2)) |=>
        (cnt == $past(cfg_int_i) - INT_W'(1) || cnt == $past(cfg_int_i)));

    // R3
    intonly_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cfg_bypass_i && cfg_int_only_i && cfg_int_i >= INT_W'(2)) |=>
        (cnt == $past(cfg_int_i) - INT_W'(1)));

    // R4
    bypass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cfg_bypass_i) |=> (div_pulse_o && bnd));
endmodule

// File: tb/test_frac_out_div.sv
`timescale 1ns/1ps
module test_frac_out_div;
    localparam longint FMAX = 64'd16777215;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic [11:0] cfg_int = 12'd5;
    logic [23:0] cfg_frac = '0;
    logic        cfg_bypass = 1'b0;
    logic        cfg_int_only = 1'b0;
    logic        cfg_ss_en = 1'b0;
    logic [23:0] cfg_ss_inc = '0;
    logic [23:0] cfg_ss_amp = '0;
    logic [15:0] cfg_ss_rate = '0;
    logic        div_pulse;

    always #10 clk = ~clk;

    frac_out_div i_frac_out_div (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
        .cfg_int_i(cfg_int), .cfg_frac_i(cfg_frac),
        .cfg_bypass_i(cfg_bypass), .cfg_int_only_i(cfg_int_only),
        .cfg_ss_en_i(cfg_ss_en), .cfg_ss_inc_i(cfg_ss_inc),
        .cfg_ss_amp_i(cfg_ss_amp), .cfg_ss_rate_i(cfg_ss_rate),
        .div_pulse_o(div_pulse)
    );

    int     n_total = 0;
    int     n_bad = 0;
    longint cyc = 0;
    longint last_cyc = 0;
    bit     have = 1'b0;
    int     exp_len = 0;
    string  cur_tag = "R1";
    longint m_acc = 0;
    longint m_off = 0;
    bit     m_down = 1'b0;
    longint m_tick = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    endtask

    task automatic model_clear();
        m_acc = 0; m_off = 0; m_down = 1'b0; m_tick = 0; have = 1'b0;
    endtask

    // Cycle-exact model of one boundary; returns the next period length.
    function automatic int model_boundary();
        longint eff, sum, amp, kk, nx;
        int n, carry;
        amp = longint'(cfg_ss_amp);
        if (cfg_int_only) eff = 0;
        else begin
            eff = longint'(cfg_frac) + m_off;
            if (eff < 0) eff = 0;
            if (eff > FMAX) eff = FMAX;
        end
        sum = m_acc + eff;
        carry = (sum > FMAX) ? 1 : 0;
        m_acc = cfg_int_only ? 0 : (sum & FMAX);
        n = (cfg_int < 12'd2) ? 2 : int'(cfg_int);
        model_boundary = cfg_bypass ? 1 : n + carry;
        if (!cfg_ss_en) begin
            m_off = 0; m_down = 1'b0; m_tick = 0;
        end else begin
            kk = (cfg_ss_rate == 0) ? 1 : longint'(cfg_ss_rate);
            if (m_tick >= kk - 1) begin
                m_tick = 0;
                if (!m_down) begin
                    nx = m_off + longint'(cfg_ss_inc);
                    if (nx >= amp) begin m_off = amp; m_down = 1'b1; end
                    else m_off = nx;
                end else begin
                    nx = m_off - longint'(cfg_ss_inc);
                    if (nx <= -amp) begin m_off = -amp; m_down = 1'b0; end
                    else m_off = nx;
                end
            end else m_tick++;
        end
    endfunction

    // One clock; sample away from the edge and check pulse intervals.
    task automatic step_cycle();
        @(negedge clk);
        cyc++;
        if (div_pulse) begin
            if (have) check((cyc - last_cyc) == exp_len, cur_tag, cyc - last_cyc, exp_len);
            exp_len = model_boundary();
            last_cyc = cyc;
            have = 1'b1;
        end
        if (cyc - last_cyc > 6000 || cyc > 150000) begin
            check(1'b0, "watchdog", cyc - last_cyc, 0);
            finish_run();
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step_cycle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step_cycle();
            check(div_pulse == 1'b0, "R7 reset low", div_pulse, 0);
        end
        model_clear();
        last_cyc = cyc;
        rst_n = 1'b1;
        step_cycle();
        check(div_pulse == 1'b1, "R7 first pulse", div_pulse, 1);
    endtask

    task automatic do_sync();
        sync_i = 1'b1;
        have = 1'b0;
        step_cycle();
        check(div_pulse == 1'b0, "R6 low after sync", div_pulse, 0);
        model_clear();
        last_cyc = cyc;
        sync_i = 1'b0;
        step_cycle();
        check(div_pulse == 1'b1, "R6 pulse after sync", div_pulse, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R7 reset state and first pulse; R1 plain integer periods
        cfg_int = 12'd5;
        do_reset();
        cur_tag = "R1"; run(60);
        // R2 half fraction alternates N and N+1
        cfg_frac = 24'h800000; cur_tag = "R2"; run(80);
        cfg_frac = 24'h000123; run(60);
        // R3 integer-only ignores the fraction
        cfg_int_only = 1'b1; cfg_frac = 24'hFFFFFF; cur_tag = "R3"; run(80);
        cfg_int_only = 1'b0;
        // R4 bypass gives back-to-back pulses
        cfg_bypass = 1'b1; cur_tag = "R4"; run(40);
        check(div_pulse == 1'b1, "R4 steady", div_pulse, 1);
        cfg_bypass = 1'b0;
        // R5 small integer values count as two
        cfg_int = 12'd0; cfg_frac = '0; cur_tag = "R5"; run(30);
        cfg_int = 12'd1; run(30);
        cfg_int = 12'd2; cfg_frac = 24'h555555; run(30);
        // R8 a write in mid-period leaves the current period alone
        cfg_int = 12'd12; cfg_frac = '0; cur_tag = "R8"; run(30);
        while (!div_pulse) step_cycle();
        run(3); cfg_int = 12'd4; run(40);
        // R6 sync restart
        cfg_int = 12'd7; cfg_frac = 24'h400000; run(10);
        do_sync(); cur_tag = "R6"; run(50);
        // R9 triangle spread with turning points
        cfg_int = 12'd6; cfg_frac = 24'h800000; cfg_ss_en = 1'b1;
        cfg_ss_inc = 24'h100000; cfg_ss_amp = 24'h300000; cfg_ss_rate = 16'd3;
        cur_tag = "R9"; run(400);
        cfg_ss_rate = 16'd0; run(200);
        // R10 clamping at both ends and spread disable
        cfg_frac = 24'h000010; cfg_ss_inc = 24'h400000; cfg_ss_amp = 24'hC00000;
        cfg_ss_rate = 16'd1; cur_tag = "R10"; run(300);
        cfg_frac = 24'hFFFFF0; run(300);
        cfg_ss_en = 1'b0; run(60);
        // R1 largest ratio with a carry
        cfg_int = 12'd4095; cfg_frac = 24'hF00000; cur_tag = "R1 max"; run(13000);
        // R2 constrained random segments
        cur_tag = "R2 random";
        for (int s = 0; s < 60; s++) begin
            cfg_int      = 12'($urandom_range(0, 20));
            cfg_frac     = 24'($urandom);
            cfg_bypass   = ($urandom_range(0, 7) == 0);
            cfg_int_only = ($urandom_range(0, 3) == 0);
            cfg_ss_en    = $urandom_range(0, 1) == 1;
            cfg_ss_inc   = 24'($urandom_range(0, 32'h3FFFFF));
            cfg_ss_amp   = 24'($urandom);
            cfg_ss_rate  = 16'($urandom_range(0, 4));
            if ($urandom_range(0, 9) == 0) do_sync();
            run($urandom_range(60, 260));
        end
        finish_run();
    end
endmodule